// File: doc/BRIEF.md
# Duplex Link Startup Handshake Controller

This block sits on the receive side of a full-duplex serial link and walks the link from power-up to a ready state by trading the two reserved training fill frames with the far end. For every received frame it is given a strobe, a flag saying whether the frame was a fill frame, the type of that fill frame, and a decode-error flag. It does not judge single frames. It gathers them into fixed windows of `WIN_FRAMES` frames and decides about the state only at the last frame of each window.

The most significant state bit is returned to the local transmitter as its fill-type select. The far end can therefore tell which training frame this side is sending. Two active-low restart inputs, one normally wired to the local transmitter's lock indication, send the machine back to its waiting state at any time. A link-ready output, active low, is retimed on the frame strobe from the "link active" state.

Top module: `link_train_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `link_state` is 00, `tx_fill_sel` is 0 and `link_rdy_n` is 1.
- R2: A low level on either `restart_a_n` or `restart_b_n` sets `link_state` to 00 at the next clock edge and clears the frame window and its accumulated results. The next decision therefore falls on the `WIN_FRAMES`-th strobe after the restart is released.
- R3: `link_state` changes only at the clock edge of the last strobe of a window (`WIN_FRAMES` = 128 strobes counted from reset or restart). On all other edges it holds its value.
- R4: State 00 (wait) moves to 01 (send FF0) at the end of its first window, whatever frames were received.
- R5: State 01 moves to 10 (send FF1) at a window end if the window held no decode error and at least one fill frame of either type. Otherwise it stays at 01.
- R6: State 10 moves to 11 (active) at a window end if the window held no error and at least one fill frame with `fill_is_ff1`=1 (FF1). With no error and no FF1 it stays at 10. With any error it falls back to 01.
- R7: In state 11, a window with more than `ERR_LIMIT` (4) errors returns the state to 01. A window with 4 or fewer errors keeps the state at 11.
- R8: `tx_fill_sel` equals bit 1 of `link_state`. A value of 0 requests FF0 and a value of 1 requests FF1.
- R9: On each frame strobe `link_rdy_n` is loaded with 0 if `link_state` is 11 and with 1 otherwise. Between strobes it holds its value, and a restart does not change it directly.
- R10: `fill_vld`, `fill_is_ff1` and `frame_err` have no effect in cycles where `frame_stb` is low. Such cycles do not count toward the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive frame-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| restart_a_n | input | 1 | Active-low restart, normally the local transmitter lock |
| restart_b_n | input | 1 | Active-low restart under user control |
| frame_stb | input | 1 | One-cycle pulse per received frame |
| fill_vld | input | 1 | Received frame is a fill frame |
| fill_is_ff1 | input | 1 | Fill type: 0 = FF0, 1 = FF1 |
| frame_err | input | 1 | Received frame had a decode error |
| link_state | output | 2 | Handshake state: 00 wait, 01 FF0, 10 FF1, 11 active |
| tx_fill_sel | output | 1 | Fill type the local transmitter should send |
| link_rdy_n | output | 1 | Active-low link ready, retimed on the strobe |

## Verification
Directed windows drive the machine up the ladder one step at a time: clean fill-free windows, clean windows carrying only FF0, and windows carrying FF1. These separate the "any fill" condition of state 01 from the "FF1 only" condition of state 10. Windows with exactly four and exactly five errors in the active state bracket the error threshold. Pulses of each restart input show that the window realigns. Random windows then mix error rates, fill types and idle cycles that carry junk on the frame inputs, and a bench model checks the state and link-ready after every strobe and every idle cycle.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    typedef enum logic [1:0] {
        LS_WAIT  = 2'b00,
        LS_SEND0 = 2'b01,
        LS_SEND1 = 2'b10,
        LS_UP    = 2'b11
    } link_st_e;

    typedef struct packed {
        logic fill_vld;
        logic fill_ff1;
        logic err;
    } frame_obs_t;

    typedef struct packed {
        logic clean;
        logic any_fill;
        logic ff1_seen;
        logic over_lim;
    } win_sum_t;

    function automatic link_st_e next_link_state(link_st_e cur, win_sum_t s);
        link_st_e nxt;
        nxt = cur;
        case (cur)
            LS_WAIT:  nxt = LS_SEND0;
            LS_SEND0: nxt = (s.clean && s.any_fill) ? LS_SEND1 : LS_SEND0;
            LS_SEND1: begin
                if (!s.clean)         nxt = LS_SEND0;
                else if (s.ff1_seen)  nxt = LS_UP;
                else                  nxt = LS_SEND1;
            end
            LS_UP:    nxt = s.over_lim ? LS_SEND0 : LS_UP;
            default:  nxt = LS_WAIT;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lsm_win_ctr.sv
module lsm_win_ctr #(
    parameter int WIN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic frame_stb,
    output logic win_end
);
    localparam int CW = (WIN < 2) ? 1 : $clog2(WIN);
    localparam logic [CW-1:0] LAST = CW'(WIN - 1);

    logic [CW-1:0] cnt_q;

    assign win_end = frame_stb && !restart && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (frame_stb) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R3: a window always restarts from frame zero after its last frame
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (cnt_q == '0));

    // R10: cycles without a strobe leave the frame count alone
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!frame_stb && !restart) |=> $stable(cnt_q));

endmodule

// File: rtl/lsm_win_acc.sv
module lsm_win_acc
    import lsm_pkg::*;
#(
    parameter int ERR_LIMIT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic       frame_stb,
    input  logic       win_end,
    input  frame_obs_t obs,
    output win_sum_t   sum
);
    localparam int EMAX = ERR_LIMIT + 1;
    localparam int EW   = $clog2(EMAX + 1);

    logic [EW-1:0] err_q;
    logic [EW-1:0] err_tot;
    logic          any_q;
    logic          ff1_q;
    logic          hit_err;

    assign hit_err = frame_stb && obs.err;

    always_comb begin
        if (hit_err && (err_q != EW'(EMAX))) err_tot = err_q + 1'b1;
        else                                  err_tot = err_q;
        sum.clean    = (err_tot == '0);
        sum.over_lim = (err_tot > EW'(ERR_LIMIT));
        sum.any_fill = any_q || (frame_stb && obs.fill_vld);
        sum.ff1_seen = ff1_q || (frame_stb && obs.fill_vld && obs.fill_ff1);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || win_end) begin
            err_q <= '0;
            any_q <= 1'b0;
            ff1_q <= 1'b0;
        end else if (frame_stb) begin
            err_q <= err_tot;
            any_q <= sum.any_fill;
            ff1_q <= sum.ff1_seen;
        end
    end

    // R5: each window starts with empty results
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (err_q == '0 && !any_q && !ff1_q));

    // R7: the error count saturates and never wraps
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        (err_q <= EW'(EMAX)));

endmodule

// File: rtl/lsm_rdy_retime.sv
module lsm_rdy_retime (
    input  logic clk,
    input  logic rst,
    input  logic frame_stb,
    input  logic link_up,
    output logic link_rdy_n
);
    always_ff @(posedge clk) begin
        if (rst)            link_rdy_n <= 1'b1;
        else if (frame_stb) link_rdy_n <= !link_up;
    end

    // R9: ready only moves on a frame strobe
    p_rdy_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(link_rdy_n));

endmodule

// File: rtl/link_train_ctrl.sv
module link_train_ctrl
    import lsm_pkg::*;
#(
    parameter int WIN_FRAMES = 128,
    parameter int ERR_LIMIT  = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart_a_n,
    input  logic       restart_b_n,
    input  logic       frame_stb,
    input  logic       fill_vld,
    input  logic       fill_is_ff1,
    input  logic       frame_err,
    output logic [1:0] link_state,
    output logic       tx_fill_sel,
    output logic       link_rdy_n
);
    logic       restart;
    logic       win_end;
    frame_obs_t obs;
    win_sum_t   sum;
    link_st_e   state_q;

    assign restart = !restart_a_n || !restart_b_n;
    assign obs     = '{fill_vld: fill_vld, fill_ff1: fill_is_ff1, err: frame_err};

    lsm_win_ctr #(.WIN(WIN_FRAMES)) u_ctr (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .frame_stb (frame_stb),
        .win_end   (win_end)
    );

    lsm_win_acc #(.ERR_LIMIT(ERR_LIMIT)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .frame_stb (frame_stb),
        .win_end   (win_end),
        .obs       (obs),
        .sum       (sum)
    );

    always_ff @(posedge clk) begin
        if (rst || restart)  state_q <= LS_WAIT;
        else if (win_end)    state_q <= next_link_state(state_q, sum);
    end

    lsm_rdy_retime u_rdy (
        .clk        (clk),
        .rst        (rst),
        .frame_stb  (frame_stb),
        .link_up    (state_q == LS_UP),
        .link_rdy_n (link_rdy_n)
    );

    assign link_state  = state_q;
    assign tx_fill_sel = state_q[1];

    // R3: state only moves at a window boundary
    p_stable_r3: assert property (@(posedge clk) disable iff (rst || restart)
        !win_end |=> $stable(state_q));

    // R2: a restart forces the wait state
    p_restart_r2: assert property (@(posedge clk) disable iff (rst)
        restart |=> (state_q == LS_WAIT));

    // R6: active is reached only from the FF1 state
    p_no_skip_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == LS_UP && $past(state_q) != LS_UP) |-> ($past(state_q) == LS_SEND1));

    // R9: ready follows the active state one strobe later
    p_rdy_follow_r9: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> (link_rdy_n == ($past(state_q) != LS_UP)));

endmodule

// File: tb/tb_link_train_ctrl.sv
module tb_link_train_ctrl;
    localparam int WIN = 128;
    localparam int LIM = 4;

    logic clk = 1'b0;
    logic rst, restart_a_n, restart_b_n, frame_stb, fill_vld, fill_is_ff1, frame_err;
    logic [1:0] link_state;
    logic tx_fill_sel, link_rdy_n;

    int total = 0;
    int bad   = 0;

    int m_state, m_cnt, m_err;
    bit m_any, m_ff1, m_rdy_n;

    always #5 clk = ~clk;

    link_train_ctrl #(.WIN_FRAMES(WIN), .ERR_LIMIT(LIM)) dut (
        .clk(clk), .rst(rst), .restart_a_n(restart_a_n), .restart_b_n(restart_b_n),
        .frame_stb(frame_stb), .fill_vld(fill_vld), .fill_is_ff1(fill_is_ff1),
        .frame_err(frame_err), .link_state(link_state), .tx_fill_sel(tx_fill_sel),
        .link_rdy_n(link_rdy_n)
    );

    function automatic int next_exp(int cur, int e, bit any, bit ff1);
        case (cur)
            0: return 1;
            1: return (e == 0 && any) ? 2 : 1;
            2: return (e != 0) ? 1 : (ff1 ? 3 : 2);
            default: return (e > LIM) ? 1 : 3;
        endcase
    endfunction

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_all(string stag);
        chk(stag, int'(link_state), m_state);
        chk("R8 fill select", int'(tx_fill_sel), m_state / 2);
        chk("R9 link ready", int'(link_rdy_n), int'(m_rdy_n));
    endtask

    // called at a negedge; returns at the next negedge
    task automatic frame(bit v, bit t, bit e);
        string tag;
        int old;
        frame_stb = 1'b1; fill_vld = v; fill_is_ff1 = t; frame_err = e;
        m_rdy_n = (m_state != 3);
        m_err += e; m_any |= v; m_ff1 |= (v & t);
        old = m_state;
        if (m_cnt == WIN - 1) begin
            m_state = next_exp(m_state, m_err, m_any, m_ff1);
            m_cnt = 0; m_err = 0; m_any = 0; m_ff1 = 0;
            case (old)
                0: tag = "R4 wait exit";
                1: tag = "R5 ff0 state";
                2: tag = "R6 ff1 state";
                default: tag = "R7 active errors";
            endcase
        end else begin
            m_cnt++;
            tag = "R3 hold mid window";
        end
        @(negedge clk);
        frame_stb = 1'b0;
        chk_all(tag);
    endtask

    task automatic idle_junk();
        frame_stb = 1'b0;
        fill_vld = 1'($urandom); fill_is_ff1 = 1'($urandom); frame_err = 1'($urandom);
        @(negedge clk);
        chk_all("R10 no strobe ignored");
        fill_vld = 0; fill_is_ff1 = 0; frame_err = 0;
    endtask

    // mode: 0 no fills, 1 FF0 only, 2 FF1 present; nerr errors at the start
    task automatic window(int mode, int nerr);
        for (int i = 0; i < WIN; i++) begin
            bit v, t;
            v = (mode != 0);
            t = (mode == 2) && (i % 3 == 0);
            frame(v, t, i < nerr);
        end
    endtask

    task automatic do_restart(bit which_a);
        if (which_a) restart_a_n = 1'b0; else restart_b_n = 1'b0;
        @(negedge clk);
        m_state = 0; m_cnt = 0; m_err = 0; m_any = 0; m_ff1 = 0;
        chk("R2 restart to wait", int'(link_state), 0);
        chk("R9 restart keeps ready", int'(link_rdy_n), int'(m_rdy_n));
        restart_a_n = 1'b1; restart_b_n = 1'b1;
    endtask

    initial begin
        #1_500_000;
        bad++; total++;
        $display("FAIL watchdog expired t=%0t", $time);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; restart_a_n = 1; restart_b_n = 1;
        frame_stb = 0; fill_vld = 0; fill_is_ff1 = 0; frame_err = 0;
        m_state = 0; m_cnt = 0; m_err = 0; m_any = 0; m_ff1 = 0; m_rdy_n = 1;
        repeat (3) @(negedge clk);
        chk("R1 reset state", int'(link_state), 0);
        chk("R1 reset ready", int'(link_rdy_n), 1);
        rst = 0;
        @(negedge clk);
        chk("R1 after release state", int'(link_state), 0);
        chk("R1 after release select", int'(tx_fill_sel), 0);

        window(0, 3);                 // R4: 00 -> 01 regardless
        window(0, 0);                 // R5: clean, no fill: stay 01
        window(1, 1);                 // R5: error: stay 01
        window(1, 0);                 // R5: -> 10
        window(1, 0);                 // R6: clean, no FF1: stay 10
        window(2, 0);                 // R6: -> 11
        window(2, LIM);               // R7: exactly 4 errors: stay 11
        window(2, 0);
        chk("R9 ready asserted", int'(link_rdy_n), 0);
        window(2, LIM + 1);           // R7: 5 errors -> 01
        window(1, 0);
        window(2, 2);                 // R6: error in 10 -> 01
        for (int k = 0; k < 50; k++) frame(1'b1, 1'b0, 1'b0);
        do_restart(1'b1);             // R2 via a
        window(1, 0);
        window(1, 0);
        for (int k = 0; k < 20; k++) begin
            frame(1'b1, 1'b1, 1'b0);
            idle_junk();              // R10
        end
        do_restart(1'b0);             // R2 via b

        for (int w = 0; w < 30; w++) begin
            int p;
            p = $urandom_range(0, 3);
            for (int i = 0; i < WIN; i++) begin
                bit e;
                e = (p == 0) ? 1'b0 : ($urandom_range(0, 255) < p * 2);
                frame(1'($urandom), 1'($urandom), e);
                if ($urandom_range(0, 7) == 0) idle_junk();
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule